// File: doc/BRIEF.md
# Framed Serial Word Transmitter with Boundary-Error Recovery

This block turns a 22-bit parallel word into a 25-bit serial frame and sends it one bit at a time, with the system clock as the time base. Each frame opens with a start bit that is always zero. The data bits follow, least significant first. Two trailing marker bits close the frame. Both markers carry the complement of the most significant data bit, so the line changes level at least once in every frame. The block makes its own bit pacing from the system clock. It also makes a one-cycle word strobe. The parallel word is sampled on the clock edge that closes that strobe cycle, so the strobe serves as the parallel clock.

The far end reports a lost word boundary by raising a pull-up indication. The transmitter then goes silent: it holds the line low and raises a quiet flag for a fixed number of system-clock cycles, which stands for one microsecond. After that it starts again on a clean word boundary, with a newly captured word. An active-low power-down input stops transmission, ignores new data and disables this recovery.

Top module: `framed_ser_tx`

## Requirements
- R1: The word strobe `word_load` is a single-cycle pulse. `din` is captured on the rising edge that ends that cycle. While words are flowing without interruption, strobes occur exactly FRAME_W*BIT_DIV cycles apart (100 with the bench parameters).
- R2: Frame bit 0, the first bit sent after a capture, is always 0.
- R3: Frame bits 1 to 22 carry `din[0]` to `din[21]` in that order.
- R4: Frame bits 23 and 24 both equal the complement of `din[21]`.
- R5: Each frame bit is held on `sdo` for exactly BIT_DIV system-clock cycles. The first bit begins in the cycle after the capture edge.
- R6: A high `link_pullup` while transmitting makes `quiet` go high in the next cycle. `quiet` then stays high for exactly QUIET_CYC cycles, and `sdo` is 0 throughout.
- R7: In the cycle after `quiet` falls, `word_load` pulses. The next frame then starts from its start bit and carries the newly captured word.
- R8: While `pwrdn_n` is low, from the next cycle on, `sdo`, `word_load` and `quiet` are all 0, and `link_pullup` has no effect. Driving `pwrdn_n` low during a quiet interval ends that interval in the next cycle.
- R9: A `link_pullup` pulse during a quiet interval does not lengthen the interval.
- R10: One cycle after `pwrdn_n` returns high, `word_load` pulses and a full new frame follows.
- R11: During and right after reset, `sdo`, `word_load` and `quiet` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Active-low power-down; when low, transmission and recovery are disabled |
| link_pullup | input | 1 | Far end signals a word-boundary error |
| din | input | 22 | Parallel data word |
| sdo | output | 1 | Serial data out |
| word_load | output | 1 | Word strobe; `din` is captured at the end of this cycle |
| quiet | output | 1 | High during the recovery silence |

## Verification
A wrong bit counter or divider shows on `sdo` within a single frame. The bit positions shift, and the strobe spacing differs from FRAME_W*BIT_DIV, so a defect appears within about 100 cycles of its cause. A control state stuck in the wrong place shows as a `quiet` interval of the wrong length, or as a strobe that is missing after quiet or after power-up. A shift register loaded in the wrong order breaks the start bit or the marker bits in the very next frame. Each of these is caught in the frame that follows it.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int DATA_W  = 22;
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        CTL_OFF   = 2'd0,
        CTL_START = 2'd1,
        CTL_RUN   = 2'd2,
        CTL_QUIET = 2'd3
    } ctl_state_e;

    // start bit at position 0, data LSB first, two inverted markers on top
    function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
        return {~d[DATA_W-1], ~d[DATA_W-1], d, 1'b0};
    endfunction

endpackage

// File: rtl/bit_timer.sv
module bit_timer
    import ser_tx_pkg::*;
#(
    parameter int BIT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic             tick,
    output logic             last_bit,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam logic [DW-1:0]    DIV_LAST = DW'(BIT_DIV - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    logic [DW-1:0] div_cnt;

    assign tick     = run && (div_cnt == DIV_LAST);
    assign last_bit = (bit_idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R5
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (bit_idx == $past(bit_idx)));

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              ser_bit
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= build_frame(din);
        end else if (shift) begin
            shreg <= {1'b0, shreg[FRAME_W-1:1]};
        end
    end

    assign ser_bit = shreg[0];

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !ser_bit);

endmodule

// File: rtl/recovery_ctrl.sv
module recovery_ctrl
    import ser_tx_pkg::*;
#(
    parameter int QUIET_CYC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrdn_n,
    input  logic       link_pullup,
    input  logic       word_done,
    output ctl_state_e state,
    output logic       run,
    output logic       load,
    output logic       quiet
);
    localparam int QW = $clog2(QUIET_CYC + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYC - 1);

    ctl_state_e nxt;
    logic [QW-1:0] qcnt;

    always_comb begin
        nxt = state;
        if (!pwrdn_n) begin
            nxt = CTL_OFF;
        end else begin
            case (state)
                CTL_OFF:   nxt = CTL_START;
                CTL_START: nxt = CTL_RUN;
                CTL_RUN:   if (link_pullup) nxt = CTL_QUIET;
                CTL_QUIET: if (qcnt == Q_LAST) nxt = CTL_START;
                default:   nxt = CTL_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CTL_OFF;
            qcnt  <= '0;
        end else begin
            state <= nxt;
            qcnt  <= (state == CTL_QUIET) ? qcnt + 1'b1 : '0;
        end
    end

    assign run   = (state == CTL_RUN);
    assign quiet = (state == CTL_QUIET);
    assign load  = pwrdn_n && ((state == CTL_START) ||
                   (run && word_done && !link_pullup));

    // R6
    quiet_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(quiet) |-> $past(link_pullup));

    // R9
    quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
        quiet |-> (qcnt < QW'(QUIET_CYC)));

endmodule

// File: rtl/framed_ser_tx.sv
module framed_ser_tx
    import ser_tx_pkg::*;
#(
    parameter int BIT_DIV   = 4,
    parameter int QUIET_CYC = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwrdn_n,
    input  logic              link_pullup,
    input  logic [DATA_W-1:0] din,
    output logic              sdo,
    output logic              word_load,
    output logic              quiet
);
    localparam logic [IDX_W-1:0] IDX_PRE = IDX_W'(FRAME_W - 2);

    ctl_state_e       state;
    logic             run, tick, last_bit, ser_bit;
    logic [IDX_W-1:0] bit_idx;

    bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .last_bit (last_bit),
        .bit_idx  (bit_idx)
    );

    recovery_ctrl #(.QUIET_CYC(QUIET_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pwrdn_n     (pwrdn_n),
        .link_pullup (link_pullup),
        .word_done   (tick && last_bit),
        .state       (state),
        .run         (run),
        .load        (word_load),
        .quiet       (quiet)
    );

    frame_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (word_load),
        .shift   (run && tick && !last_bit),
        .din     (din),
        .ser_bit (ser_bit)
    );

    assign sdo = (state == CTL_RUN) ? ser_bit : 1'b0;

    // R8
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwrdn_n |=> (!sdo && !word_load && !quiet));

    // R4
    marker_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && bit_idx == IDX_PRE && pwrdn_n && !link_pullup) |=> (sdo == $past(sdo)));

    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_load |=> !word_load);

endmodule

// File: tb/tb_framed_ser_tx.sv
module tb_framed_ser_tx;
    localparam int CLK_PER = 10;
    localparam int BIT_DIV = 4;
    localparam int QCYC    = 40;
    localparam int DW      = 22;
    localparam int FW      = DW + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwrdn_n = 1'b1;
    logic          link_pullup = 1'b0;
    logic [DW-1:0] din = '0;
    logic          sdo, word_load, quiet;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    framed_ser_tx #(.BIT_DIV(BIT_DIV), .QUIET_CYC(QCYC)) dut (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .link_pullup(link_pullup),
        .din(din), .sdo(sdo), .word_load(word_load), .quiet(quiet)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired got %0d exp <150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, act, exp);
        end
    endtask

    // call at a negedge where word_load is high
    task automatic collect(input logic [DW-1:0] d);
        logic [FW-1:0] got;
        logic [FW-1:0] exp;
        int early;
        early = 0;
        din = d;
        exp = {~d[DW-1], ~d[DW-1], d, 1'b0};
        @(posedge clk);
        for (int k = 0; k < FW; k++) begin
            @(negedge clk);
            got[k] = sdo;
            for (int c = 1; c < BIT_DIV; c++) begin
                if (word_load) early++;
                if (sdo != got[k]) early += 100;   // R5 bit held for BIT_DIV cycles
                @(negedge clk);
            end
            if (k != FW-1 && word_load) early++;
        end
        chk(got[0] == 1'b0, "R2 start bit", got[0], 0);
        chk(got[22:1] == d, "R3 data order", got[22:1], d);
        chk(got[24:23] == {2{~d[DW-1]}}, "R4 markers", got[24:23], {2{~d[DW-1]}});
        chk(early == 0, "R5 bit width / stray strobe", early, 0);
        chk(word_load == 1'b1, "R1 strobe spacing", word_load, 1);
    endtask

    task automatic wait_load();
        while (!word_load) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!sdo && !word_load && !quiet, "R11 reset outputs", {sdo, word_load, quiet}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sdo && !quiet, "R11 after reset", {sdo, quiet}, 0);
    endtask

    task automatic t_frames();
        wait_load();
        collect(22'h000000);
        collect(22'h3FFFFF);
        collect(22'h2AAAAA);
        collect(22'h155555);
        collect(22'h200001);
    endtask

    task automatic t_quiet();
        int n;
        wait_load();
        din = 22'h0F0F0F;
        @(posedge clk);
        repeat (10) @(negedge clk);
        link_pullup = 1'b1;
        @(negedge clk);
        link_pullup = 1'b0;
        chk(quiet == 1'b1, "R6 quiet rises", quiet, 1);
        n = 0;
        while (quiet && n < 3*QCYC) begin
            if (sdo) chk(1'b0, "R6 sdo low in quiet", sdo, 0);
            link_pullup = (n == 10);   // R9 pulse during quiet
            n++;
            @(negedge clk);
        end
        link_pullup = 1'b0;
        chk(n == QCYC, "R6 R9 quiet length", n, QCYC);
        chk(word_load == 1'b1, "R7 strobe after quiet", word_load, 1);
        collect(22'h3C3A5E);   // R7 fresh word
    endtask

    task automatic t_pwrdn();
        int bad;
        bad = 0;
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk(!sdo && !word_load && !quiet, "R8 pwrdn outputs", {sdo, word_load, quiet}, 0);
        for (int i = 0; i < 30; i++) begin
            link_pullup = (i == 5);
            din = 22'(i * 777);
            @(negedge clk);
            if (sdo || word_load || quiet) bad++;
        end
        link_pullup = 1'b0;
        chk(bad == 0, "R8 pullup ignored in pwrdn", bad, 0);
        pwrdn_n = 1'b1;
        @(negedge clk);
        chk(word_load == 1'b1, "R10 strobe after power-up", word_load, 1);
        collect(22'h1234AB);
    endtask

    task automatic t_pwrdn_in_quiet();
        wait_load();
        din = 22'h000FFF;
        @(posedge clk);
        repeat (5) @(negedge clk);
        link_pullup = 1'b1;
        @(negedge clk);
        link_pullup = 1'b0;
        repeat (5) @(negedge clk);
        chk(quiet == 1'b1, "R6 quiet held", quiet, 1);
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk(quiet == 1'b0, "R8 pwrdn ends quiet", quiet, 0);
        pwrdn_n = 1'b1;
        @(negedge clk);
        chk(word_load == 1'b1, "R10 restart after abort", word_load, 1);
        collect(22'h2F00F1);
    endtask

    initial begin
        t_reset();
        t_frames();
        t_quiet();
        t_pwrdn();
        t_pwrdn_in_quiet();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule